// File: doc/BRIEF.md
# SCSI Controller Command Gate and Interrupt Cause Register

This block sits between the host's command register write port and the bus-side sequencer of a SCSI protocol controller. Each command byte the host writes is classified into a command group. The block then compares that group with the controller's present connection state. A command whose state condition holds is issued to the sequencer as a registered action strobe. A command whose condition fails does not run, and it raises an illegal-command cause instead.

The block also owns the eight-bit interrupt cause register. Event pulses from the bus side set cause bits. So do illegal commands and reported bus resets. The interrupt request line is high while any cause bit is set. A host read strobe clears the register. An accepted chip reset wipes the register and emits a one-cycle pulse, which the surrounding logic uses to return the connection state to disconnected.

Top module: `scsi_cmd_gate`

## Requirements
- R1: After reset, cause_o is 0x00, irq_o is low and act_valid_o, fifo_flush_o, chip_rst_o and bus_rst_o are low.
- R2: Command byte bit 7 is the DMA flag and bits 6:0 are the opcode. In the cycle after an accepted write, act_valid_o is high, act_cmd_o carries the opcode and act_dma_o carries bit 7.
- R3: Opcodes 0x00 to 0x03 are accepted in every connection state (conn_state_i 0, 1, 2 or 3). Opcodes 0x00 to 0x02 set no cause bit.
- R4: Opcodes 0x10, 0x11, 0x12, 0x18, 0x1A and 0x1B are accepted only when conn_state_i is 1 (connected initiator).
- R5: Opcodes 0x20 to 0x25 and 0x27 to 0x2B are accepted only when conn_state_i is 2 (connected target in a message phase).
- R6: Opcodes 0x40 to 0x47 are accepted only when conn_state_i is 0 (disconnected).
- R7: A write that is not accepted gives no action strobe and sets cause bit 6. Every opcode outside the sets in R3 to R6 is rejected in every state, and conn_state_i 3 accepts only the R3 opcodes.
- R8: An accepted opcode 0x03 sets cause bit 7 when rpt_rst_dis_i is low, and leaves bit 7 unchanged when rpt_rst_dis_i is high.
- R9: A pulse on evt_i[k] (k = 0..5: select without attention, select with attention, reselected, function done, bus service, disconnect) sets cause bit k. Cause bits accumulate until they are cleared.
- R10: irq_o is high exactly when cause_o is nonzero. irq_clr_i clears every cause bit, but bits set by events or commands in the same cycle survive.
- R11: An accepted opcode 0x02 clears cause_o at the next edge, and this overrides same-cycle events and irq_clr_i. chip_rst_o is high for the one following cycle.
- R12: fifo_flush_o, chip_rst_o and bus_rst_o pulse for one cycle after an accepted opcode 0x01, 0x02 or 0x03 respectively. At most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Host command write strobe |
| cmd_byte_i | input | 8 | Command byte: DMA flag in bit 7, opcode in bits 6:0 |
| conn_state_i | input | 2 | 0 disconnected, 1 initiator connected, 2 target in message phase, 3 unused |
| rpt_rst_dis_i | input | 1 | Suppresses the bus reset cause bit |
| evt_i | input | 6 | Bus-side event pulses for cause bits 0 to 5 |
| irq_clr_i | input | 1 | Host read strobe that clears the cause register |
| cause_o | output | 8 | Interrupt cause register |
| irq_o | output | 1 | Interrupt request |
| act_valid_o | output | 1 | Accepted command strobe |
| act_cmd_o | output | 7 | Opcode of the accepted command |
| act_dma_o | output | 1 | DMA flag of the accepted command |
| fifo_flush_o | output | 1 | FIFO flush action strobe |
| chip_rst_o | output | 1 | Chip reset strobe; forces the disconnected state |
| bus_rst_o | output | 1 | Bus reset action strobe |

## Verification
The embedded properties check several behaviours on every cycle. A rejected write must leave no strobe and must set the illegal bit. Group 2, 3 and 4 opcodes must not issue outside their required state. A suppressed bus reset must not raise bit 7. Events must latch, an idle cause must not drop, the action strobes must stay one-hot, and the register must be empty while chip_rst_o is high. Other behaviours need the bench's scenarios, because they depend on exact values and sequences. These are the full legality table across all four state codes, opcode and DMA flag transport, accumulation over several events, and the priority between a clear and a same-cycle set or chip reset.

// File: rtl/scsi_cmd_pkg.sv
package scsi_cmd_pkg;

  typedef enum logic [1:0] {
    LINK_FREE    = 2'd0,
    LINK_INIT    = 2'd1,
    LINK_TGT_MSG = 2'd2,
    LINK_RSVD    = 2'd3
  } link_e;

  typedef enum logic [2:0] {
    GRP_NONE = 3'd0,
    GRP_ANY  = 3'd1,
    GRP_INIT = 3'd2,
    GRP_MSG  = 3'd3,
    GRP_FREE = 3'd4
  } grp_e;

  localparam int OP_W = 7;

  localparam logic [OP_W-1:0] OP_FLUSH   = 7'h01;
  localparam logic [OP_W-1:0] OP_CHIPRST = 7'h02;
  localparam logic [OP_W-1:0] OP_BUSRST  = 7'h03;

endpackage

// File: rtl/cmd_classify.sv
module cmd_classify
  import scsi_cmd_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  link_e           link_i,
  output grp_e            grp_o,
  output logic            legal_o
);

  always_comb begin
    if (op_i <= 7'h03)
      grp_o = GRP_ANY;
    else if (op_i inside {7'h10, 7'h11, 7'h12, 7'h18, 7'h1A, 7'h1B})
      grp_o = GRP_INIT;
    else if ((op_i >= 7'h20 && op_i <= 7'h25) || (op_i >= 7'h27 && op_i <= 7'h2B))
      grp_o = GRP_MSG;
    else if (op_i[6:3] == 4'b1000)
      grp_o = GRP_FREE;
    else
      grp_o = GRP_NONE;
  end

  always_comb begin
    case (grp_o)
      GRP_ANY:  legal_o = 1'b1;
      GRP_INIT: legal_o = (link_i == LINK_INIT);
      GRP_MSG:  legal_o = (link_i == LINK_TGT_MSG);
      GRP_FREE: legal_o = (link_i == LINK_FREE);
      default:  legal_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int EVT_W = 6,
  localparam int CAUSE_W = EVT_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [EVT_W-1:0]   evt_i,
  input  logic               illegal_i,
  input  logic               busrst_i,
  input  logic               clr_i,
  input  logic               wipe_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               irq_o
);

  logic [CAUSE_W-1:0] set_v;
  assign set_v = {busrst_i, illegal_i, evt_i};

  for (genvar k = 0; k < CAUSE_W; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cause_o[k] <= 1'b0;
      else if (wipe_i) cause_o[k] <= 1'b0;
      else             cause_o[k] <= (cause_o[k] & ~clr_i) | set_v[k];
    end
  end

  assign irq_o = |cause_o;

  AST_EVT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i && !wipe_i) |=> ((cause_o[EVT_W-1:0] & $past(evt_i)) == $past(evt_i))); // R9

  AST_CAUSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i && !wipe_i) |=> irq_o); // R10

endmodule

// File: rtl/act_issue.sv
module act_issue
  import scsi_cmd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            accept_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            dma_i,
  output logic            valid_o,
  output logic [OP_W-1:0] cmd_o,
  output logic            dma_o,
  output logic            flush_o,
  output logic            chip_o,
  output logic            busrst_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      cmd_o    <= '0;
      dma_o    <= 1'b0;
      flush_o  <= 1'b0;
      chip_o   <= 1'b0;
      busrst_o <= 1'b0;
    end else begin
      valid_o  <= accept_i;
      flush_o  <= accept_i && (op_i == OP_FLUSH);
      chip_o   <= accept_i && (op_i == OP_CHIPRST);
      busrst_o <= accept_i && (op_i == OP_BUSRST);
      if (accept_i) begin
        cmd_o <= op_i;
        dma_o <= dma_i;
      end
    end
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({flush_o, chip_o, busrst_o})); // R12

  AST_STROBE_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o || chip_o || busrst_o) |-> valid_o); // R12

endmodule

// File: rtl/scsi_cmd_gate.sv
module scsi_cmd_gate
  import scsi_cmd_pkg::*;
#(
  parameter int EVT_W = 6,
  localparam int CAUSE_W = EVT_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_wr_i,
  input  logic [7:0]         cmd_byte_i,
  input  logic [1:0]         conn_state_i,
  input  logic               rpt_rst_dis_i,
  input  logic [EVT_W-1:0]   evt_i,
  input  logic               irq_clr_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               irq_o,
  output logic               act_valid_o,
  output logic [OP_W-1:0]    act_cmd_o,
  output logic               act_dma_o,
  output logic               fifo_flush_o,
  output logic               chip_rst_o,
  output logic               bus_rst_o
);

  logic [OP_W-1:0] op;
  link_e           link;
  grp_e            grp;
  logic            legal;
  logic            accept;
  logic            reject;
  logic            busrst_rpt;
  logic            wipe;

  assign op   = cmd_byte_i[OP_W-1:0];
  assign link = link_e'(conn_state_i);

  cmd_classify u_classify (
    .op_i    (op),
    .link_i  (link),
    .grp_o   (grp),
    .legal_o (legal)
  );

  assign accept     = cmd_wr_i && legal;
  assign reject     = cmd_wr_i && !legal;
  assign busrst_rpt = accept && (op == OP_BUSRST) && !rpt_rst_dis_i;
  assign wipe       = accept && (op == OP_CHIPRST);

  irq_cause_reg #(.EVT_W(EVT_W)) u_cause (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .illegal_i (reject),
    .busrst_i  (busrst_rpt),
    .clr_i     (irq_clr_i),
    .wipe_i    (wipe),
    .cause_o   (cause_o),
    .irq_o     (irq_o)
  );

  act_issue u_issue (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .op_i     (op),
    .dma_i    (cmd_byte_i[7]),
    .valid_o  (act_valid_o),
    .cmd_o    (act_cmd_o),
    .dma_o    (act_dma_o),
    .flush_o  (fifo_flush_o),
    .chip_o   (chip_rst_o),
    .busrst_o (bus_rst_o)
  );

  AST_REJECT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && !legal) |=> (cause_o[EVT_W] && !act_valid_o)); // R7

  AST_GRP_INIT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && grp == GRP_INIT && link != LINK_INIT) |=> !act_valid_o); // R4

  AST_GRP_MSG_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && grp == GRP_MSG && link != LINK_TGT_MSG) |=> !act_valid_o); // R5

  AST_GRP_FREE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && grp == GRP_FREE && link != LINK_FREE) |=> !act_valid_o); // R6

  AST_RST_RPT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && op == OP_BUSRST && rpt_rst_dis_i && !cause_o[CAUSE_W-1]) |=> !cause_o[CAUSE_W-1]); // R8

  AST_CHIP_RST_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_rst_o |-> (cause_o == '0)); // R11

endmodule

// File: tb/tb_scsi_cmd_gate.sv
module tb_scsi_cmd_gate;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [1:0] conn_state = 2'd0;
  logic       rpt_rst_dis = 1'b0;
  logic [5:0] evt = 6'h00;
  logic       irq_clr = 1'b0;

  logic [7:0] cause;
  logic       irq;
  logic       act_valid;
  logic [6:0] act_cmd;
  logic       act_dma;
  logic       fifo_flush;
  logic       chip_rst;
  logic       bus_rst;

  always #4 clk = ~clk;

  scsi_cmd_gate dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .cmd_wr_i      (cmd_wr),
    .cmd_byte_i    (cmd_byte),
    .conn_state_i  (conn_state),
    .rpt_rst_dis_i (rpt_rst_dis),
    .evt_i         (evt),
    .irq_clr_i     (irq_clr),
    .cause_o       (cause),
    .irq_o         (irq),
    .act_valid_o   (act_valid),
    .act_cmd_o     (act_cmd),
    .act_dma_o     (act_dma),
    .fifo_flush_o  (fifo_flush),
    .chip_rst_o    (chip_rst),
    .bus_rst_o     (bus_rst)
  );

  typedef struct packed {
    logic [7:0] req;
    logic       valid;
    logic [6:0] cmd;
    logic       dma;
    logic       flush;
    logic       chip;
    logic       brst;
    logic [7:0] cause;
  } exp_t;

  exp_t sb[$];
  int   n_vec = 0;
  int   n_bad = 0;
  logic [7:0] m_cause = 8'h00;
  bit   done = 1'b0;

  // Legality from the requirement tables R3..R7.
  function automatic bit legal_f(input logic [6:0] op, input logic [1:0] st);
    if (op <= 7'h03) return 1'b1;
    if (op == 7'h10 || op == 7'h11 || op == 7'h12 || op == 7'h18 || op == 7'h1A || op == 7'h1B)
      return st == 2'd1;
    if ((op >= 7'h20 && op <= 7'h25) || (op >= 7'h27 && op <= 7'h2B))
      return st == 2'd2;
    if (op >= 7'h40 && op <= 7'h47)
      return st == 2'd0;
    return 1'b0;
  endfunction

  task automatic step(input bit wr, input logic [7:0] b, input logic [1:0] st,
                      input bit rdis, input logic [5:0] ev, input bit clr, input int req);
    exp_t e;
    bit   ok;
    @(negedge clk);
    cmd_wr = wr; cmd_byte = b; conn_state = st; rpt_rst_dis = rdis; evt = ev; irq_clr = clr;
    @(posedge clk);
    ok = wr && legal_f(b[6:0], st);
    e = '0;
    e.req   = 8'(req);
    e.valid = ok;
    e.cmd   = b[6:0];
    e.dma   = b[7];
    e.flush = ok && b[6:0] == 7'h01;
    e.chip  = ok && b[6:0] == 7'h02;
    e.brst  = ok && b[6:0] == 7'h03;
    if (e.chip) m_cause = 8'h00;
    else begin
      m_cause = (clr ? 8'h00 : m_cause) | {2'b00, ev};
      if (wr && !ok) m_cause[6] = 1'b1;
      if (e.brst && !rdis) m_cause[7] = 1'b1;
    end
    e.cause = m_cause;
    sb.push_back(e);
  endtask

  task automatic idle(input int req);
    step(1'b0, 8'h00, 2'd0, 1'b0, 6'h00, 1'b0, req);
  endtask

  // Monitor: compares one cycle after each driven step.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      bit   bad;
      e = sb.pop_front();
      n_vec++;
      bad = (act_valid !== e.valid) || (cause !== e.cause) || (irq !== (|e.cause)) ||
            (fifo_flush !== e.flush) || (chip_rst !== e.chip) || (bus_rst !== e.brst) ||
            (e.valid && ((act_cmd !== e.cmd) || (act_dma !== e.dma)));
      if (bad) begin
        n_bad++;
        $display("FAIL R%0d: got valid=%b cmd=%h dma=%b fl=%b cr=%b br=%b cause=%h irq=%b exp valid=%b cmd=%h dma=%b fl=%b cr=%b br=%b cause=%h irq=%b",
                 e.req, act_valid, act_cmd, act_dma, fifo_flush, chip_rst, bus_rst, cause, irq,
                 e.valid, e.cmd, e.dma, e.flush, e.chip, e.brst, e.cause, |e.cause);
      end
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    n_vec++;
    if (cause !== 8'h00 || irq !== 1'b0 || act_valid !== 1'b0 ||
        fifo_flush !== 1'b0 || chip_rst !== 1'b0 || bus_rst !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got cause=%h irq=%b valid=%b exp cause=00 irq=0 valid=0", cause, irq, act_valid);
    end

    // R3: always-legal opcodes in every state, incl. state code 3
    for (int s = 0; s < 4; s++) begin
      step(1'b1, 8'h00, 2'(s), 1'b0, 6'h00, 1'b0, 3);
      step(1'b1, 8'h01, 2'(s), 1'b0, 6'h00, 1'b0, 12); // R12 flush strobe
    end

    // R2: DMA flag and opcode transport
    step(1'b1, 8'h90, 2'd1, 1'b0, 6'h00, 1'b0, 2);
    step(1'b1, 8'h1B, 2'd1, 1'b0, 6'h00, 1'b0, 2);
    step(1'b1, 8'hC1, 2'd0, 1'b0, 6'h00, 1'b0, 2);

    // R4: initiator group outside its state
    step(1'b1, 8'h12, 2'd0, 1'b0, 6'h00, 1'b0, 4);
    step(1'b0, 8'h00, 2'd0, 1'b0, 6'h00, 1'b1, 10);
    step(1'b1, 8'h18, 2'd2, 1'b0, 6'h00, 1'b1, 4);
    step(1'b1, 8'h1A, 2'd1, 1'b0, 6'h00, 1'b1, 4);

    // R5: message group
    step(1'b1, 8'h27, 2'd2, 1'b0, 6'h00, 1'b0, 5);
    step(1'b1, 8'hA5, 2'd2, 1'b0, 6'h00, 1'b0, 5);
    step(1'b1, 8'h2B, 2'd1, 1'b0, 6'h00, 1'b0, 5);
    step(1'b0, 8'h00, 2'd0, 1'b0, 6'h00, 1'b1, 10);

    // R6: disconnected group
    step(1'b1, 8'h47, 2'd0, 1'b0, 6'h00, 1'b0, 6);
    step(1'b1, 8'h40, 2'd1, 1'b0, 6'h00, 1'b1, 6);
    step(1'b1, 8'h44, 2'd2, 1'b0, 6'h00, 1'b1, 6);

    // R7: undefined opcodes rejected in every state; state 3 accepts only group 1
    for (int s = 0; s < 4; s++) begin
      step(1'b1, 8'h26, 2'(s), 1'b0, 6'h00, 1'b1, 7);
      step(1'b1, 8'h13, 2'(s), 1'b0, 6'h00, 1'b1, 7);
      step(1'b1, 8'hD0, 2'(s), 1'b0, 6'h00, 1'b1, 7);
    end
    step(1'b1, 8'h10, 2'd3, 1'b0, 6'h00, 1'b1, 7);
    step(1'b1, 8'h20, 2'd3, 1'b0, 6'h00, 1'b1, 7);
    step(1'b1, 8'h41, 2'd3, 1'b0, 6'h00, 1'b1, 7);
    step(1'b0, 8'h00, 2'd0, 1'b0, 6'h00, 1'b1, 10);

    // R8: bus reset reporting enabled and disabled
    step(1'b1, 8'h03, 2'd1, 1'b0, 6'h00, 1'b0, 8);
    step(1'b0, 8'h00, 2'd0, 1'b0, 6'h00, 1'b1, 10);
    step(1'b1, 8'h03, 2'd0, 1'b1, 6'h00, 1'b0, 8);
    step(1'b1, 8'h83, 2'd2, 1'b1, 6'h00, 1'b0, 8);

    // R9: each event bit, accumulating
    for (int k = 0; k < 6; k++)
      step(1'b0, 8'h00, 2'd0, 1'b0, 6'(1 << k), 1'b0, 9);
    idle(9);

    // R10: clear with a same-cycle event keeps the new bit
    step(1'b0, 8'h00, 2'd0, 1'b0, 6'h08, 1'b1, 10);
    step(1'b1, 8'h55, 2'd0, 1'b0, 6'h00, 1'b1, 10);
    step(1'b0, 8'h00, 2'd0, 1'b0, 6'h00, 1'b1, 10);
    idle(10);

    // R11: chip reset wipes causes, beats same-cycle events
    step(1'b0, 8'h00, 2'd0, 1'b0, 6'h31, 1'b0, 11);
    step(1'b1, 8'h02, 2'd2, 1'b0, 6'h06, 1'b0, 11);
    idle(11);
    step(1'b1, 8'h7F, 2'd1, 1'b0, 6'h00, 1'b0, 11);
    step(1'b1, 8'h82, 2'd1, 1'b0, 6'h20, 1'b1, 11);
    idle(12);
    idle(12);

    @(negedge clk);
    @(negedge clk);
    finish_up();
  end

endmodule